// File: doc/BRIEF.md
# Line Printer Code Translator

This block turns one print line, stored as 16-bit words that each hold two 7-bit printer character codes, into a stream of ASCII bytes. A pulse on `start` with a column count latches the line length. The block then fetches words one at a time through a request/valid port, splits each word into its two columns and checks each code for odd parity. It looks each code up in a 128-entry table and offers one ASCII byte per column on a valid/ready output.

When the last column has been accepted, the block pulses `done`. At the same time it presents a line-level parity flag. The flag reports a parity-check failure if any column on the line had an even number of one bits. A code with bad parity, or a code outside the printable set, is printed as a space.

The character table is built into the block. It is indexed by the full 7-bit code, so a code with bad parity reaches its own table entry, and that entry holds a space.

Top module: `lpc_xlate`

## Requirements
- R1: After reset, `word_req`, `ch_valid`, `done`, `par_err` and `busy` are all low.
- R2: A `start` pulse taken while idle, with `line_len` from 1 to 132, raises `busy` and `word_req` in the next cycle with `word_addr` = 0. Words are requested at addresses 0, 1, 2, … in order. `word_req` and `word_addr` hold until `word_valid` is seen, and `word_valid` is ignored while `word_req` is low.
- R3: In each word, bits 14:8 form the first column and bits 6:0 form the second. Bits 15 and 7 have no effect on the output.
- R4: A code with an odd number of ones has a character value in its bits 5:0 (bit 6 is the parity bit). The values map to ASCII as follows. Value 0 gives space (0x20). Values 1–26 give 'A'–'Z'. Values 27–36 give '0'–'9'. Values 37–48 give, in order, `.` `,` `(` `)` `+` `-` `*` `/` `$` `=` `#` `&`.
- R5: A code with odd parity whose value is 49–63 outputs space (0x20) and is not a parity error.
- R6: A code with an even number of ones outputs space (0x20) and counts as a parity error.
- R7: Exactly `line_len` bytes are emitted, in column order. With an odd length, the second column of the final word is never emitted.
- R8: While `ch_valid` is high and `ch_ready` is low, `ch_valid` and `ch_data` hold. No new word is requested until both columns of the current word, or the last column of the line, have been accepted.
- R9: `done` is high for one cycle, in the cycle after the last byte is accepted. In that same cycle `par_err` is high exactly when some column of the line had a parity error. `par_err` keeps this value until the next accepted `start` and is low in the cycle after that `start`.
- R10: `start` is ignored while `busy` is high, and also when `line_len` is 0 or greater than 132.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a line (one-cycle pulse) |
| line_len | input | 8 | Column count, sampled with `start` |
| word_req | output | 1 | Word fetch request |
| word_addr | output | 7 | Word index within the line |
| word_valid | input | 1 | Fetched word present on `word_data` |
| word_data | input | 16 | Fetched word, two packed codes |
| ch_valid | output | 1 | ASCII byte available |
| ch_data | output | 8 | ASCII byte |
| ch_ready | input | 1 | Consumer takes the byte |
| done | output | 1 | Line complete (one cycle) |
| par_err | output | 1 | Parity error seen on the last line |
| busy | output | 1 | Line in progress |

## Verification
The lines are built from arithmetic word sequences, and the step values are chosen so that each kind of code appears. A constant word of clean letters shows whether the column order and the lookup are right. Incrementing sequences sweep all 128 codes and separate the three cases of good character, unused value and bad parity. Words with bits 15 and 7 set show that those bits are ignored.

Lengths of 1, 2, odd values and 132 test where the line ends. Each line runs with the consumer always ready, ready on alternate cycles, or ready one cycle in three, so the stall behaviour is exercised. Junk `word_valid` pulses and a stray `start` during a line show that inputs arriving out of turn have no effect.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EMIT  = 2'd2
    } lpc_state_e;

    localparam logic [7:0] ASC_SPACE  = 8'h20;
    localparam logic [7:0] ASC_LETTER = 8'h41;
    localparam logic [7:0] ASC_DIGIT  = 8'h30;

    localparam int VAL_LETTER_LO = 1;
    localparam int VAL_DIGIT_LO  = 27;
    localparam int VAL_PUNCT_LO  = 37;
    localparam int VAL_PUNCT_HI  = 48;
endpackage

// File: rtl/lpc_code_rom.sv
module lpc_code_rom #(
    parameter int CODE_W = 7,
    parameter int CHAR_W = 8
) (
    input  logic [CODE_W-1:0] addr,
    output logic [CHAR_W-1:0] data
);
    import lpc_pkg::*;

    localparam int DEPTH = 1 << CODE_W;
    localparam int VAL_W = CODE_W - 1;

    function automatic logic [CHAR_W-1:0] punct_of(input int k);
        logic [7:0] p;
        case (k)
            0:  p = 8'h2E;
            1:  p = 8'h2C;
            2:  p = 8'h28;
            3:  p = 8'h29;
            4:  p = 8'h2B;
            5:  p = 8'h2D;
            6:  p = 8'h2A;
            7:  p = 8'h2F;
            8:  p = 8'h24;
            9:  p = 8'h3D;
            10: p = 8'h23;
            11: p = 8'h26;
            default: p = ASC_SPACE;
        endcase
        return CHAR_W'(p);
    endfunction

    function automatic logic [CHAR_W-1:0] entry_of(input int idx);
        logic [CODE_W-1:0] c;
        int                v;
        c = CODE_W'(idx);
        v = idx % (1 << VAL_W);
        if (($countones(c) % 2) == 0)   return CHAR_W'(ASC_SPACE);
        if (v < VAL_LETTER_LO)          return CHAR_W'(ASC_SPACE);
        if (v < VAL_DIGIT_LO)           return CHAR_W'(int'(ASC_LETTER) + v - VAL_LETTER_LO);
        if (v < VAL_PUNCT_LO)           return CHAR_W'(int'(ASC_DIGIT) + v - VAL_DIGIT_LO);
        if (v <= VAL_PUNCT_HI)          return punct_of(v - VAL_PUNCT_LO);
        return CHAR_W'(ASC_SPACE);
    endfunction

    logic [CHAR_W-1:0] table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign table_q[i] = entry_of(i);
    end

    assign data = table_q[addr];
endmodule

// File: rtl/lpc_col_pick.sv
module lpc_col_pick #(
    parameter int WORD_W = 16,
    parameter int CODE_W = 7
) (
    input  logic [WORD_W-1:0] word,
    input  logic              sel,
    output logic [CODE_W-1:0] code,
    output logic              bad_par
);
    localparam int HALF  = WORD_W / 2;
    localparam int LANES = 2;

    logic [CODE_W-1:0] lane_code [LANES];
    logic              lane_bad  [LANES];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lane_code[j] = word[(LANES-1-j)*HALF +: CODE_W];
        assign lane_bad[j]  = ~(^lane_code[j]);
    end

    always_comb begin
        code    = sel ? lane_code[1] : lane_code[0];
        bad_par = sel ? lane_bad[1]  : lane_bad[0];
    end
endmodule

// File: rtl/lpc_xlate.sv
module lpc_xlate #(
    parameter int MAX_COLS = 132,
    parameter int WORD_W   = 16,
    parameter int CODE_W   = 7,
    parameter int CHAR_W   = 8,
    localparam int MAX_WORDS = (MAX_COLS + 1) / 2,
    localparam int ADDR_W    = $clog2(MAX_WORDS),
    localparam int LEN_W     = $clog2(MAX_COLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  line_len,
    output logic              word_req,
    output logic [ADDR_W-1:0] word_addr,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              ch_valid,
    output logic [CHAR_W-1:0] ch_data,
    input  logic              ch_ready,
    output logic              done,
    output logic              par_err,
    output logic              busy
);
    import lpc_pkg::*;

    localparam logic [LEN_W-1:0]  MAX_LEN  = LEN_W'(MAX_COLS);
    localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    typedef struct packed {
        lpc_state_e        state;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] word;
        logic              col;
        logic              err_run;
        logic              err_flag;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    logic [CODE_W-1:0] cur_code;
    logic              cur_bad;
    logic              len_ok;
    logic              take;
    logic              last_col;

    lpc_col_pick #(
        .WORD_W (WORD_W),
        .CODE_W (CODE_W)
    ) u_pick (
        .word    (r_q.word),
        .sel     (r_q.col),
        .code    (cur_code),
        .bad_par (cur_bad)
    );

    lpc_code_rom #(
        .CODE_W (CODE_W),
        .CHAR_W (CHAR_W)
    ) u_rom (
        .addr (cur_code),
        .data (ch_data)
    );

    assign len_ok   = (line_len != '0) && (line_len <= MAX_LEN);
    assign take     = (r_q.state == ST_EMIT) && ch_ready;
    assign last_col = (r_q.cnt + LEN_ONE) == r_q.len;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start && len_ok) begin
                    r_d.state    = ST_FETCH;
                    r_d.len      = line_len;
                    r_d.cnt      = '0;
                    r_d.addr     = '0;
                    r_d.col      = 1'b0;
                    r_d.err_run  = 1'b0;
                    r_d.err_flag = 1'b0;
                end
            end
            ST_FETCH: begin
                if (word_valid) begin
                    r_d.word  = word_data;
                    r_d.col   = 1'b0;
                    r_d.state = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (take) begin
                    r_d.cnt     = r_q.cnt + LEN_ONE;
                    r_d.err_run = r_q.err_run | cur_bad;
                    if (last_col) begin
                        r_d.state    = ST_IDLE;
                        r_d.done     = 1'b1;
                        r_d.err_flag = r_q.err_run | cur_bad;
                    end else if (r_q.col) begin
                        r_d.state = ST_FETCH;
                        r_d.addr  = r_q.addr + ADDR_ONE;
                    end else begin
                        r_d.col = 1'b1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign word_req  = (r_q.state == ST_FETCH);
    assign word_addr = r_q.addr;
    assign ch_valid  = (r_q.state == ST_EMIT);
    assign done      = r_q.done;
    assign par_err   = r_q.err_flag;
    assign busy      = (r_q.state != ST_IDLE);
endmodule

// File: rtl/lpc_xlate_chk.sv
module lpc_xlate_chk #(
    parameter int MAX_COLS = 132,
    parameter int ADDR_W   = 7,
    parameter int LEN_W    = 8,
    parameter int CHAR_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LEN_W-1:0]  line_len,
    input logic              word_req,
    input logic [ADDR_W-1:0] word_addr,
    input logic              word_valid,
    input logic              ch_valid,
    input logic [CHAR_W-1:0] ch_data,
    input logic              ch_ready,
    input logic              done,
    input logic              par_err,
    input logic              busy
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_COLS);

    logic go_ok, go_bad;
    assign go_ok  = start && !busy && (line_len != '0) && (line_len <= MAX_LEN);
    assign go_bad = start && !busy && ((line_len == '0) || (line_len > MAX_LEN));

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !busy && !done && !par_err) // R1
        else $error("reset idle");
    AST_START_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        go_ok |=> busy && word_req && (word_addr == '0)) // R2
        else $error("start fetch");
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        word_req && !word_valid |=> word_req && $stable(word_addr)) // R2
        else $error("req hold");
    AST_CH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid && !ch_ready |=> ch_valid && $stable(ch_data)) // R8
        else $error("ch hold");
    AST_NO_PREFETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_req && ch_valid)) // R8
        else $error("prefetch");
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) // R9
        else $error("done pulse");
    AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(ch_valid && ch_ready)) // R9
        else $error("done timing");
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        go_ok |=> !par_err) // R9
        else $error("err clear");
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !go_ok && !done |=> $stable(par_err)) // R9
        else $error("err hold");
    AST_BAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        go_bad |=> !busy) // R10
        else $error("bad start");
endmodule

bind lpc_xlate lpc_xlate_chk #(
    .MAX_COLS (MAX_COLS),
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .CHAR_W   (CHAR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .line_len   (line_len),
    .word_req   (word_req),
    .word_addr  (word_addr),
    .word_valid (word_valid),
    .ch_valid   (ch_valid),
    .ch_data    (ch_data),
    .ch_ready   (ch_ready),
    .done       (done),
    .par_err    (par_err),
    .busy       (busy)
);

// File: tb/lpc_xlate_tb.sv
`timescale 1ns/1ps
module lpc_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  line_len = '0;
    logic        word_req;
    logic [6:0]  word_addr;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = '0;
    logic        ch_valid;
    logic [7:0]  ch_data;
    logic        ch_ready = 1'b0;
    logic        done;
    logic        par_err;
    logic        busy;

    int total = 0;
    int bad   = 0;
    int ticks = 0;

    always #2 clk = ~clk;

    lpc_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .line_len(line_len),
        .word_req(word_req), .word_addr(word_addr), .word_valid(word_valid),
        .word_data(word_data), .ch_valid(ch_valid), .ch_data(ch_data),
        .ch_ready(ch_ready), .done(done), .par_err(par_err), .busy(busy)
    );

    always @(posedge clk) begin
        ticks <= ticks + 1;
        if (ticks > 150000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: got hang exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0h exp %0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] ref_char(input logic [6:0] c);
        int v;
        v = int'(c[5:0]);
        if (($countones(c) % 2) == 0) return 8'h20;
        if (v == 0)  return 8'h20;
        if (v <= 26) return 8'(8'h40 + v);
        if (v <= 36) return 8'(8'h30 + v - 27);
        case (v)
            37: return 8'h2E;  38: return 8'h2C;  39: return 8'h28;
            40: return 8'h29;  41: return 8'h2B;  42: return 8'h2D;
            43: return 8'h2A;  44: return 8'h2F;  45: return 8'h24;
            46: return 8'h3D;  47: return 8'h23;  48: return 8'h26;
            default: return 8'h20;
        endcase
    endfunction

    function automatic string req_of(input logic [6:0] c);
        if (($countones(c) % 2) == 0) return "R6";
        if (int'(c[5:0]) > 48) return "R5";
        return "R4/R3";
    endfunction

    task automatic run_line(input int len, input logic [15:0] base, input logic [15:0] step,
                            input int rmode, input bit noise);
        logic [7:0]  expc [132];
        logic [6:0]  codes [132];
        bit          experr;
        int          k;
        int          widx;
        bit          fin;
        experr = 1'b0;
        for (int c = 0; c < len; c++) begin
            logic [15:0] w;
            w = 16'(base + step * 16'(c / 2));
            codes[c] = (c % 2 == 0) ? w[14:8] : w[6:0];
            expc[c]  = ref_char(codes[c]);
            if (($countones(codes[c]) % 2) == 0) experr = 1'b1;
        end
        k = 0; widx = 0; fin = 1'b0;
        @(negedge clk);
        start = 1'b1; line_len = 8'(len);
        @(negedge clk);
        start = 1'b0;
        check(busy && word_req && !par_err, "R2/R9 start", {busy, word_req, par_err}, 3'b110);
        for (int cyc = 0; cyc < 3000; cyc++) begin
            bit rdy;
            if (done) begin
                check(k == len, "R7 count", k, len);
                check(par_err == experr, "R9 par_err", par_err, experr);
                fin = 1'b1;
                break;
            end
            case (rmode)
                1:       rdy = (cyc % 2 == 1);
                2:       rdy = (cyc % 3 == 2);
                default: rdy = 1'b1;
            endcase
            ch_ready = rdy;
            if (word_req) begin
                check(int'(word_addr) == widx, "R2 addr", word_addr, widx);
                word_valid = 1'b1;
                word_data  = 16'(base + step * 16'(widx));
                widx++;
            end else begin
                word_valid = noise;
                word_data  = 16'h0101;
            end
            if (ch_valid && rdy) begin
                if (k >= len) check(1'b0, "R7 extra", k, len);
                else check(ch_data == expc[k], req_of(codes[k]), ch_data, expc[k]);
                k++;
            end
            start    = noise && (cyc == 3);
            line_len = (noise && cyc == 3) ? 8'd5 : 8'(len);
            @(negedge clk);
        end
        if (!fin) check(1'b0, "R9 no done", 0, 1);
        start = 1'b0; word_valid = 1'b0; ch_ready = 1'b0;
        @(negedge clk);
        check(!done, "R9 pulse", done, 0);
    endtask

    // {rmode, len, base, step}
    localparam int NV = 8;
    localparam logic [47:0] VEC [NV] = '{
        {8'd0, 8'd20,  16'h0102, 16'h0000},
        {8'd0, 8'd132, 16'h0000, 16'h0101},
        {8'd1, 8'd37,  16'h8080, 16'h0301},
        {8'd2, 8'd7,   16'h4001, 16'h0000},
        {8'd2, 8'd64,  16'h3B31, 16'h0103},
        {8'd1, 8'd2,   16'h1A5B, 16'h0000},
        {8'd0, 8'd1,   16'h7000, 16'h0000},
        {8'd1, 8'd131, 16'hFFFF, 16'hEEEF}
    };

    initial begin
        repeat (3) @(negedge clk);
        check(!word_req && !ch_valid && !done && !par_err && !busy, "R1 reset",
              {word_req, ch_valid, done, par_err, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !word_req, "R1 after release", busy, 0);

        for (int i = 0; i < NV; i++) begin
            run_line(int'(VEC[i][39:32]), VEC[i][31:16], VEC[i][15:0], int'(VEC[i][47:40]), 1'b0);
        end

        // R10: out-of-range lengths ignored
        start = 1'b1; line_len = 8'd0;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !word_req, "R10 len0", busy, 0);
        start = 1'b1; line_len = 8'd133;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !word_req, "R10 len133", busy, 0);

        // R10/R2: stray start and junk word_valid during a line
        run_line(9, 16'h0304, 16'h0102, 2, 1'b1);

        // R3: bits 15 and 7 ignored
        run_line(4, 16'h8182, 16'h0000, 0, 1'b0);

        // R9: error flag held, then cleared by next start
        run_line(3, 16'h0303, 16'h0000, 0, 1'b0);
        repeat (4) @(negedge clk);
        check(par_err && !done, "R9 hold", par_err, 1);
        run_line(2, 16'h0102, 16'h0000, 1, 1'b0);
        check(!par_err, "R9 clean", par_err, 0);

        // R7: full-length clean line, consumer slow
        run_line(132, 16'h4001, 16'h0000, 2, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule